// File: doc/BRIEF.md
# Multi-Phase Buck Fault Protection Sequencer

This block is the digital sequencer of a multi-phase buck regulator controller with two to `NCH` interleaved channels. It turns digitized comparator flags into per-channel PWM pin modes and soft-start capacitor controls. The flags are supply good, programmable undervoltage-lockout good, per-channel overcurrent, overvoltage, output above the power-good threshold, and soft-start level. It also drives a power-good pull-down and an overvoltage indication. The analog comparators, ramp generator, reference DAC and current sense amplifiers sit outside.

While either supply monitor reports low, the sequencer holds a power-on-reset state. In that state it reads which PWM pins are strapped high, and that sets the number of active phases. Once both monitors are good, the soft-start capacitor charges and the enabled phases switch. The phases stay off while the soft-start node sits below the ramp valley.

An overcurrent on an enabled channel releases all PWM pins to high impedance and discharges the soft-start node. The block then retries once the node has fallen below the restart level. The third overcurrent latches the converter off. An overvoltage drives every enabled phase low and latches. Only a new power-on reset clears either latch, the overcurrent count, or a power-good indication that has been granted.

Top module: `buck_fault_seq`

## Requirements
- R1: While `rst` is high or either `vcc_ok` or `uvlo_ok` is low, every PWM channel reads code 2'b00 (high impedance; 2'b01 is forced low, 2'b10 is normal switching). In this state `ss_charge`=0, `ss_discharge`=1, `pg_low`=1 and `ovp_out`=0.
- R2: The phase mask is taken from `strap_hi` during power-on reset. Channels 0 and 1 are always enabled. Channel k≥2 is enabled only if no channel from 2 to k is strapped, so strapping channel 3 gives three phases and strapping channel 2 gives two. A disabled channel always outputs 2'b00, and its overcurrent flag has no effect.
- R3: After both supplies report good, `ss_charge`=1 and `ss_discharge`=0, never both at once. Enabled channels output 2'b00 while `ss_shut` (soft-start below ramp valley) is high, and 2'b10 otherwise.
- R4: When `ss_full` rises during soft-start, the block enters run, and enabled channels keep switching (2'b10) while no fault is present.
- R5: An overvoltage during soft-start, run or hiccup drives enabled channels to 2'b01, sets `ovp_out` and sets `pg_low`. All three hold after the flag clears, until a power-fail.
- R6: The first and second overcurrent on an enabled channel set all channels to 2'b00 with `ss_discharge`=1 and `ss_charge`=0. Soft-start resumes (`ss_charge`=1) once `ss_low` (below restart level) is high.
- R7: The third overcurrent since power-on reset latches all channels at 2'b00 with `ss_discharge`=1, regardless of `ss_low`. A power-fail clears the latch and the count.
- R8: `pg_low` is released once the block is in run with `pg_above` high. After that, it stays released when `pg_above` falls, through hiccup and overcurrent latch-off, until an overvoltage or a power-fail.
- R9: Each flag passes a two-flop synchronizer. An output responds on the third rising clock edge after an input change.
- R10: When overvoltage and overcurrent arrive in the same cycle, the overvoltage response wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ok | input | 1 | Supply monitor above rising threshold |
| uvlo_ok | input | 1 | Programmable lockout input above threshold |
| oc_flag | input | NCH | Per-channel sampled current over limit |
| ov_flag | input | 1 | Output above overvoltage threshold |
| pg_above | input | 1 | Output above power-good threshold |
| ss_full | input | 1 | Soft-start node fully charged |
| ss_low | input | 1 | Soft-start node below restart level |
| ss_shut | input | 1 | Soft-start node below ramp valley |
| strap_hi | input | NCH | Per-channel PWM pin strapped to supply |
| pwm_mode | output | 2*NCH | Per-channel pin mode, channel i at bits 2i+1:2i |
| ss_charge | output | 1 | Enable soft-start charge current |
| ss_discharge | output | 1 | Enable soft-start discharge current |
| pg_low | output | 1 | Pull power-good pin low |
| ovp_out | output | 1 | Overvoltage indication |

## Verification
The hardest state to reach is overcurrent latch-off. It needs three separate overcurrent events, each followed by a full discharge-and-restart. The soft-start flags must be sequenced in order, and the flag must drop before the restart so that one long pulse is not counted twice. The bench drives that sequence as a task and runs it under random strap patterns. Some of the runs aim overcurrent at a disabled channel, which must be ignored. A following power cycle confirms that a single event then yields only a hiccup.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [2:0] {
    ST_RESET     = 3'd0,
    ST_SOFTSTART = 3'd1,
    ST_RUN       = 3'd2,
    ST_HICCUP    = 3'd3,
    ST_OVP_LATCH = 3'd4,
    ST_OCP_LATCH = 3'd5
  } fps_state_t;

  localparam logic [1:0] PWM_HIZ  = 2'b00;
  localparam logic [1:0] PWM_LOW  = 2'b01;
  localparam logic [1:0] PWM_NORM = 2'b10;
endpackage

// File: rtl/fps_sync.sv
module fps_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fps_phase_cfg.sv
module fps_phase_cfg #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sample,
  input  logic [NCH-1:0] strap,
  output logic [NCH-1:0] en
);
  logic [NCH-1:0] en_d;

  // a strapped channel turns off itself and every channel above it
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i < 2) begin : g_base
      assign en_d[i] = 1'b1;
    end else begin : g_opt
      assign en_d[i] = en_d[i-1] & ~strap[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         en <= '1;
    else if (sample) en <= en_d;
  end
endmodule

// File: rtl/fps_seq.sv
module fps_seq
  import fps_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int OCP_TRIES = 3,
  localparam int CW       = $clog2(OCP_TRIES + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           por_ok,
  input  logic           ov,
  input  logic [NCH-1:0] oc,
  input  logic [NCH-1:0] en,
  input  logic           pg_above,
  input  logic           ss_full,
  input  logic           ss_low,
  output fps_state_t     state_q,
  output fps_state_t     state_d,
  output logic           pg_ok_d,
  output logic [CW-1:0]  oc_cnt
);
  logic [CW-1:0] cnt_d;
  logic          oc_hit;
  logic          pg_ok_q;

  assign oc_hit = |(oc & en);

  always_comb begin
    state_d = state_q;
    cnt_d   = oc_cnt;
    if (!por_ok) begin
      state_d = ST_RESET;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_RESET: state_d = ST_SOFTSTART;
        ST_SOFTSTART, ST_RUN: begin
          if (ov) begin
            state_d = ST_OVP_LATCH;
          end else if (oc_hit) begin
            cnt_d   = oc_cnt + 1'b1;
            state_d = (oc_cnt == CW'(OCP_TRIES - 1)) ? ST_OCP_LATCH : ST_HICCUP;
          end else if (state_q == ST_SOFTSTART && ss_full) begin
            state_d = ST_RUN;
          end
        end
        ST_HICCUP: begin
          if (ov)          state_d = ST_OVP_LATCH;
          else if (ss_low) state_d = ST_SOFTSTART;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_comb begin
    if (state_d == ST_RESET || state_d == ST_OVP_LATCH) pg_ok_d = 1'b0;
    else pg_ok_d = pg_ok_q | ((state_d == ST_RUN) & pg_above);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RESET;
      oc_cnt  <= '0;
      pg_ok_q <= 1'b0;
    end else begin
      state_q <= state_d;
      oc_cnt  <= cnt_d;
      pg_ok_q <= pg_ok_d;
    end
  end
endmodule

// File: rtl/fps_out.sv
module fps_out
  import fps_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  fps_state_t       state_d,
  input  logic [NCH-1:0]   en,
  input  logic             ss_shut,
  input  logic             pg_ok_d,
  output logic [2*NCH-1:0] pwm_mode,
  output logic             ss_charge,
  output logic             ss_discharge,
  output logic             pg_low,
  output logic             ovp_out
);
  logic active;
  assign active = (state_d == ST_SOFTSTART) || (state_d == ST_RUN);

  for (genvar i = 0; i < NCH; i++) begin : g_pin
    logic [1:0] code_d;
    always_comb begin
      if (!en[i])                      code_d = PWM_HIZ;
      else if (active)                 code_d = ss_shut ? PWM_HIZ : PWM_NORM;
      else if (state_d == ST_OVP_LATCH) code_d = PWM_LOW;
      else                             code_d = PWM_HIZ;
    end
    always_ff @(posedge clk) begin
      if (rst) pwm_mode[2*i +: 2] <= PWM_HIZ;
      else     pwm_mode[2*i +: 2] <= code_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_charge    <= 1'b0;
      ss_discharge <= 1'b1;
      pg_low       <= 1'b1;
      ovp_out      <= 1'b0;
    end else begin
      ss_charge    <= active;
      ss_discharge <= (state_d == ST_RESET) || (state_d == ST_HICCUP) ||
                      (state_d == ST_OCP_LATCH);
      pg_low       <= ~pg_ok_d;
      ovp_out      <= (state_d == ST_OVP_LATCH);
    end
  end
endmodule

// File: rtl/buck_fault_seq.sv
module buck_fault_seq
  import fps_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int OCP_TRIES = 3,
  localparam int CW       = $clog2(OCP_TRIES + 1),
  localparam int SW       = 2 * NCH + 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vcc_ok,
  input  logic             uvlo_ok,
  input  logic [NCH-1:0]   oc_flag,
  input  logic             ov_flag,
  input  logic             pg_above,
  input  logic             ss_full,
  input  logic             ss_low,
  input  logic             ss_shut,
  input  logic [NCH-1:0]   strap_hi,
  output logic [2*NCH-1:0] pwm_mode,
  output logic             ss_charge,
  output logic             ss_discharge,
  output logic             pg_low,
  output logic             ovp_out
);
  logic [SW-1:0]  raw_flags, sync_flags;
  logic [NCH-1:0] strap_s, oc_s, en_mask;
  logic           vcc_s, uvlo_s, ov_s, pg_s, full_s, low_s, shut_s;
  fps_state_t     state_q, state_d;
  logic           pg_ok_d;
  logic [CW-1:0]  oc_cnt;

  assign raw_flags = {strap_hi, oc_flag, vcc_ok, uvlo_ok, ov_flag,
                      pg_above, ss_full, ss_low, ss_shut};

  fps_sync #(.W(SW)) u_sync (
    .clk(clk), .rst(rst), .d(raw_flags), .q(sync_flags)
  );

  assign {strap_s, oc_s, vcc_s, uvlo_s, ov_s, pg_s, full_s, low_s, shut_s} = sync_flags;

  fps_phase_cfg #(.NCH(NCH)) u_cfg (
    .clk(clk), .rst(rst), .sample(state_q == ST_RESET),
    .strap(strap_s), .en(en_mask)
  );

  fps_seq #(.NCH(NCH), .OCP_TRIES(OCP_TRIES)) u_seq (
    .clk(clk), .rst(rst), .por_ok(vcc_s & uvlo_s), .ov(ov_s), .oc(oc_s),
    .en(en_mask), .pg_above(pg_s), .ss_full(full_s), .ss_low(low_s),
    .state_q(state_q), .state_d(state_d), .pg_ok_d(pg_ok_d), .oc_cnt(oc_cnt)
  );

  fps_out #(.NCH(NCH)) u_out (
    .clk(clk), .rst(rst), .state_d(state_d), .en(en_mask), .ss_shut(shut_s),
    .pg_ok_d(pg_ok_d), .pwm_mode(pwm_mode), .ss_charge(ss_charge),
    .ss_discharge(ss_discharge), .pg_low(pg_low), .ovp_out(ovp_out)
  );
endmodule

// File: rtl/buck_fault_seq_chk.sv
module buck_fault_seq_chk
  import fps_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int OCP_TRIES = 3,
  localparam int CW       = $clog2(OCP_TRIES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [2*NCH-1:0] pwm_mode,
  input logic             ss_charge,
  input logic             ss_discharge,
  input logic             ovp_out,
  input fps_state_t       state_q,
  input logic [CW-1:0]    oc_cnt,
  input logic [NCH-1:0]   en_mask
);
  logic dis_bad, any_norm;
  always_comb begin
    dis_bad  = 1'b0;
    any_norm = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (!en_mask[i] && pwm_mode[2*i +: 2] != PWM_HIZ) dis_bad = 1'b1;
      if (pwm_mode[2*i +: 2] == PWM_NORM) any_norm = 1'b1;
    end
  end

  AST_DISABLED_HIZ: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_RESET && $past(state_q) != ST_RESET) |-> !dis_bad); // R2
  AST_CHARGE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ss_charge && ss_discharge)); // R3
  AST_OVP_NO_SWITCH: assert property (@(posedge clk) disable iff (rst)
    ovp_out |-> !any_norm); // R5
  AST_OVP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OVP_LATCH) |=> (state_q == ST_OVP_LATCH || state_q == ST_RESET)); // R5
  AST_DISCHARGE_HIZ: assert property (@(posedge clk) disable iff (rst)
    ss_discharge |-> (pwm_mode == '0)); // R6
  AST_OCP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OCP_LATCH) |=> (state_q == ST_OCP_LATCH || state_q == ST_RESET)); // R7
  AST_CNT_NO_DROP: assert property (@(posedge clk) disable iff (rst)
    (oc_cnt != '0) |=> (oc_cnt >= $past(oc_cnt) || state_q == ST_RESET)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    oc_cnt <= CW'(OCP_TRIES)); // R7
endmodule

bind buck_fault_seq buck_fault_seq_chk #(.NCH(NCH), .OCP_TRIES(OCP_TRIES)) u_chk (
  .clk(clk), .rst(rst), .pwm_mode(pwm_mode), .ss_charge(ss_charge),
  .ss_discharge(ss_discharge), .ovp_out(ovp_out), .state_q(state_q),
  .oc_cnt(oc_cnt), .en_mask(en_mask)
);

// File: tb/buck_fault_seq_bench.sv
module buck_fault_seq_bench;
  localparam int NCH = 4;
  localparam logic [1:0] HIZ = 2'b00, LOW = 2'b01, NORM = 2'b10;

  logic clk = 1'b0, rst = 1'b1;
  logic vcc_ok = 1'b0, uvlo_ok = 1'b0, ov_flag = 1'b0, pg_above = 1'b0;
  logic ss_full = 1'b0, ss_low = 1'b1, ss_shut = 1'b1;
  logic [NCH-1:0] oc_flag = '0, strap_hi = '0;
  logic [2*NCH-1:0] pwm_mode;
  logic ss_charge, ss_discharge, pg_low, ovp_out;
  int n_tests = 0, n_fail = 0;
  logic [NCH-1:0] cur_strap;

  always #4 clk = ~clk;

  buck_fault_seq #(.NCH(NCH), .OCP_TRIES(3)) u_buck_fault_seq (
    .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .uvlo_ok(uvlo_ok), .oc_flag(oc_flag),
    .ov_flag(ov_flag), .pg_above(pg_above), .ss_full(ss_full), .ss_low(ss_low),
    .ss_shut(ss_shut), .strap_hi(strap_hi), .pwm_mode(pwm_mode),
    .ss_charge(ss_charge), .ss_discharge(ss_discharge), .pg_low(pg_low),
    .ovp_out(ovp_out)
  );

  function automatic logic [NCH-1:0] exp_mask(input logic [NCH-1:0] s);
    logic [NCH-1:0] m;
    m[0] = 1'b1;
    m[1] = 1'b1;
    for (int k = 2; k < NCH; k++) m[k] = m[k-1] & ~s[k];
    return m;
  endfunction

  function automatic logic [2*NCH-1:0] exp_pwm(input logic [NCH-1:0] m, input logic [1:0] c);
    logic [2*NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[2*i +: 2] = m[i] ? c : HIZ;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_off(input string req);
    check(req, 32'(pwm_mode), 32'(0));
    check(req, 32'({ss_charge, ss_discharge, pg_low, ovp_out}), 32'(4'b0110));
  endtask

  task automatic bring_up(input logic [NCH-1:0] s);
    logic [NCH-1:0] m;
    m = exp_mask(s);
    cur_strap = s;
    vcc_ok = 0; uvlo_ok = 0; oc_flag = '0; ov_flag = 0; pg_above = 0;
    ss_full = 0; ss_low = 1; ss_shut = 1; strap_hi = s;
    step(5);
    check_off("R1 power-fail state");
    vcc_ok = 1; uvlo_ok = 1;
    step(4);
    check("R3 charge on", 32'({ss_charge, ss_discharge}), 32'(2'b10));
    check("R3 held below valley", 32'(pwm_mode), 32'(0));
    ss_shut = 0; ss_low = 0;
    step(4);
    check("R3 R2 ramp switching", 32'(pwm_mode), 32'(exp_pwm(m, NORM)));
    ss_full = 1;
    step(4);
    check("R4 run switching", 32'(pwm_mode), 32'(exp_pwm(m, NORM)));
    pg_above = 1;
    step(4);
    check("R8 pg released", 32'(pg_low), 32'(0));
    pg_above = 0;
    step(4);
    check("R8 pg held after drop", 32'(pg_low), 32'(0));
  endtask

  task automatic oc_event(input int ch, input bit latch);
    logic [NCH-1:0] m;
    m = exp_mask(cur_strap);
    oc_flag[ch] = 1'b1;
    step(4);
    oc_flag = '0;
    if (!m[ch]) begin
      check("R2 disabled oc ignored", 32'(pwm_mode), 32'(exp_pwm(m, NORM)));
      return;
    end
    check(latch ? "R7 latch pins hiz" : "R6 hiccup pins hiz", 32'(pwm_mode), 32'(0));
    check(latch ? "R7 latch discharge" : "R6 hiccup discharge",
          32'({ss_charge, ss_discharge}), 32'(2'b01));
    ss_full = 0; ss_shut = 1;
    step(3);
    ss_low = 1;
    step(4);
    if (latch) begin
      check("R7 stays off at low ss", 32'({ss_charge, ss_discharge}), 32'(2'b01));
      check("R7 pins stay hiz", 32'(pwm_mode), 32'(0));
      check("R8 pg kept in latch-off", 32'(pg_low), 32'(0));
    end else begin
      check("R6 restart charging", 32'({ss_charge, ss_discharge}), 32'(2'b10));
      ss_low = 0; ss_shut = 0; ss_full = 1;
      step(4);
      check("R6 back to switching", 32'(pwm_mode), 32'(exp_pwm(m, NORM)));
      check("R8 pg kept after hiccup", 32'(pg_low), 32'(0));
    end
  endtask

  task automatic ov_event();
    logic [NCH-1:0] m;
    m = exp_mask(cur_strap);
    ov_flag = 1;
    step(4);
    check("R5 enabled pins low", 32'(pwm_mode), 32'(exp_pwm(m, LOW)));
    check("R5 ovp and pg", 32'({ovp_out, pg_low}), 32'(2'b11));
    ov_flag = 0; pg_above = 1;
    step(5);
    check("R5 latched after clear", 32'({ovp_out, pg_low, pwm_mode}),
          32'({2'b11, exp_pwm(m, LOW)}));
  endtask

  initial begin
    void'($urandom(32'd2024));
    step(3);
    check_off("R1 under rst");
    rst = 0;
    step(4);
    check_off("R1 supplies low");

    // R9 latency and R5 on a four-phase start
    bring_up('0);
    ov_flag = 1;
    step(2);
    check("R9 no change after two edges", 32'(ovp_out), 32'(0));
    step(1);
    check("R9 change on third edge", 32'(ovp_out), 32'(1));
    ov_flag = 0;
    step(4);
    check("R5 latch holds", 32'(ovp_out), 32'(1));

    // R1 lockout input alone forces reset
    uvlo_ok = 0;
    step(4);
    check_off("R1 uvlo drop");

    // R2 three phases, oc on disabled channel 3
    bring_up(4'b1000);
    oc_event(3, 0);
    // R2 two phases
    bring_up(4'b0100);
    oc_event(2, 0);
    oc_event(3, 0);

    // R7 latch after third event, count cleared by power cycle
    bring_up('0);
    oc_event(1, 0);
    oc_event(2, 0);
    oc_event(0, 1);
    bring_up('0);
    oc_event(0, 0);

    // R10 simultaneous faults
    bring_up('0);
    oc_flag[1] = 1; ov_flag = 1;
    step(4);
    oc_flag = '0;
    check("R10 ov wins", 32'({ovp_out, pwm_mode}), 32'({1'b1, exp_pwm('1, LOW)}));
    ov_flag = 0;

    // R5 overvoltage during hiccup
    bring_up('0);
    oc_flag[0] = 1;
    step(4);
    oc_flag = '0;
    ss_full = 0;
    ov_flag = 1;
    step(4);
    check("R5 ov in hiccup", 32'({ovp_out, pg_low, pwm_mode}), 32'({2'b11, exp_pwm('1, LOW)}));
    ov_flag = 0;

    for (int it = 0; it < 12; it++) begin
      logic [NCH-1:0] s;
      int kind;
      s = NCH'($urandom);
      kind = int'($urandom % 3);
      bring_up(s);
      case (kind)
        0: ov_event();
        1: oc_event(int'($urandom % NCH), 0);
        default: for (int j = 0; j < 3; j++) oc_event(0, j == 2);
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule